// File: doc/BRIEF.md
# Accumulator Processor Instruction Sequencer

This block is the control unit and register datapath of a small accumulator machine. A three-bit step counter produces one-hot timing states. A decoder turns the three opcode bits of the instruction word into eight one-hot operation lines. Each register transfer is enabled by the product of one operation line and one timing state. The block holds a 12-bit program counter, a 12-bit address register, 16-bit instruction, data and accumulator registers, a carry flag and an indirect flag.

It drives an external single-port synchronous memory with a one-cycle read latency. The read address is steered one state ahead of the cycle that consumes the data, so no wait states are needed. Each instruction is fetched and decoded. When the indirect bit is set, one pointer dereference follows. The seven memory-reference operations then run to completion. Opcode 7 returns to the fetch state right after decode and changes nothing else.

Instruction word layout: bit 15 is the indirect flag, bits 14:12 are the opcode and bits 11:0 are the address. The opcodes are: 0 bitwise AND, 1 add, 2 load, 3 store, 4 jump, 5 call with saved return address, 6 increment-and-skip-if-zero, 7 non-memory operation.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is asserted, the timing state is 0 (one-hot `0000001`), and the program counter, address register and accumulator are all zero.
- R2: In state 0 the address register takes the program counter. In state 1 the instruction register takes the memory word at that address and the program counter increments by one.
- R3: In state 2 the address register takes instruction bits 11:0 and the indirect flag takes bit 15.
- R4: In state 3, if the opcode is not 7 and the indirect flag is 1, the address register takes bits 11:0 of the memory word it points to. If the indirect flag is 0, the address register is kept.
- R5: Opcode 0 sets the accumulator to the accumulator AND the operand word. Opcode 2 loads the operand word. Each takes 6 cycles.
- R6: Opcode 1 adds the operand word to the accumulator. The carry out of bit 15 goes to the carry flag. It takes 6 cycles.
- R7: Opcode 3 writes the accumulator to the operand address and takes 5 cycles.
- R8: Opcode 4 loads the program counter with the effective address and takes 5 cycles.
- R9: Opcode 5 stores the return address (the already incremented program counter, zero-extended) at the effective address. Execution then continues at the effective address plus one. It takes 6 cycles.
- R10: Opcode 6 writes the operand word plus one back to memory. It increments the program counter once more when the result is zero. It takes 7 cycles.
- R11: Opcode 7, with or without bit 15, takes 4 cycles. It leaves the program counter, accumulator, carry flag and memory unchanged.
- R12: The memory is addressed by the low `ADDR_W` bits of the 12-bit address. The write strobe is high in exactly one cycle for opcodes 3, 5 and 6, and in no cycle for the other opcodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | ADDR_W | Memory address (read address is one state early) |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Registered memory read data |
| pc_q | output | 12 | Program counter |
| ar_q | output | 12 | Address register |
| ir_q | output | 16 | Instruction register |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| e_q | output | 1 | Carry flag |
| i_q | output | 1 | Indirect flag |
| t_q | output | 7 | One-hot timing state |

## Verification
The hardest cases to reach are the skip after an increment that wraps to zero, and indirect references whose pointer words carry upper address bits that the memory ignores. The bench reaches both by sweeping pairs of operand values that include 0xFFFF and 0x0000. Every sweep runs once with direct addressing and once through pointer words with bits 11:7 set. The same pointers send the call and the jump to program counter values with high bits set, and fetch then has to wrap back into the 128-word memory. A return through an indirect jump closes each call.

// File: rtl/acc_seq_core.sv
`timescale 1ns/1ps
module acc_seq_core #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              mem_we,
  input  logic [15:0]       mem_rdata,
  output logic [11:0]       pc_q,
  output logic [11:0]       ar_q,
  output logic [15:0]       ir_q,
  output logic [15:0]       dr_q,
  output logic [15:0]       ac_q,
  output logic              e_q,
  output logic              i_q,
  output logic [6:0]        t_q
);
  localparam int STEPS = 7;
  localparam int SC_W  = $clog2(STEPS);
  localparam int OPS   = 8;

  logic [SC_W-1:0]  sc;
  logic [STEPS-1:0] t;
  logic [OPS-1:0]   d;
  logic [16:0]      sum;

  assign t   = STEPS'(1) << sc;
  assign d   = OPS'(1) << ir_q[14:12];
  assign t_q = t;
  assign sum = {1'b0, ac_q} + {1'b0, dr_q};

  logic ind_rd, dr_rd, and_x, add_x, lda_x, sta_x, bun_x;
  logic bsa_w, bsa_j, isz_inc, isz_w, io_end, clr_sc;

  assign ind_rd  = t[3] & ~d[7] & i_q;
  assign dr_rd   = t[4] & (d[0] | d[1] | d[2] | d[6]);
  assign and_x   = t[5] & d[0];
  assign add_x   = t[5] & d[1];
  assign lda_x   = t[5] & d[2];
  assign sta_x   = t[4] & d[3];
  assign bun_x   = t[4] & d[4];
  assign bsa_w   = t[4] & d[5];
  assign bsa_j   = t[5] & d[5];
  assign isz_inc = t[5] & d[6];
  assign isz_w   = t[6] & d[6];
  assign io_end  = t[3] & d[7];
  assign clr_sc  = io_end | and_x | add_x | lda_x | sta_x | bun_x | bsa_j | isz_w;

  assign mem_addr  = t[0]   ? pc_q[ADDR_W-1:0] :
                     t[2]   ? ir_q[ADDR_W-1:0] :
                     ind_rd ? mem_rdata[ADDR_W-1:0] :
                              ar_q[ADDR_W-1:0];
  assign mem_we    = sta_x | bsa_w | isz_w;
  assign mem_wdata = sta_x ? ac_q : bsa_w ? {4'b0, pc_q} : dr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc   <= '0;
      pc_q <= '0;
      ar_q <= '0;
      ir_q <= '0;
      dr_q <= '0;
      ac_q <= '0;
      e_q  <= 1'b0;
      i_q  <= 1'b0;
    end else begin
      sc <= clr_sc ? '0 : sc + 1'b1;
      if (t[0]) ar_q <= pc_q;
      if (t[1]) begin
        ir_q <= mem_rdata;
        pc_q <= pc_q + 12'd1;
      end
      if (t[2]) begin
        ar_q <= ir_q[11:0];
        i_q  <= ir_q[15];
      end
      if (ind_rd)  ar_q <= mem_rdata[11:0];
      if (dr_rd)   dr_q <= mem_rdata;
      if (and_x)   ac_q <= ac_q & dr_q;
      if (add_x)   {e_q, ac_q} <= sum;
      if (lda_x)   ac_q <= dr_q;
      if (bun_x)   pc_q <= ar_q;
      if (bsa_w)   ar_q <= ar_q + 12'd1;
      if (bsa_j)   pc_q <= ar_q;
      if (isz_inc) dr_q <= dr_q + 16'd1;
      if (isz_w && dr_q == 16'd0) pc_q <= pc_q + 12'd1;
    end
  end
endmodule

// File: rtl/acc_seq_core_chk.sv
`timescale 1ns/1ps
module acc_seq_core_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_wdata,
  input logic              mem_we,
  input logic [15:0]       mem_rdata,
  input logic [11:0]       pc_q,
  input logic [11:0]       ar_q,
  input logic [15:0]       ir_q,
  input logic [15:0]       dr_q,
  input logic [15:0]       ac_q,
  input logic              e_q,
  input logic              i_q,
  input logic [6:0]        t_q
);
  logic [2:0] op;
  assign op = ir_q[14:12];

  // R2
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_q[0] |=> t_q[1] && ar_q == $past(pc_q));

  // R2
  fetch_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_q[1] |=> ir_q == $past(mem_rdata) && pc_q == $past(pc_q) + 12'd1);

  // R3
  decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_q[2] |=> ar_q == $past(ir_q[11:0]) && i_q == $past(ir_q[15]));

  // R4
  indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_q[3] && op != 3'd7 && i_q |=> ar_q == $past(mem_rdata[11:0]));

  // R6
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_q[5] && op == 3'd1 |=> {e_q, ac_q} == {1'b0, $past(ac_q)} + {1'b0, $past(dr_q)});

  // R8
  jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_q[4] && op == 3'd4 |=> t_q[0] && pc_q == $past(ar_q));

  // R10
  skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_q[6] |=> t_q[0] && pc_q == $past(pc_q) + {11'd0, $past(dr_q) == 16'd0});

  // R11
  no_mem_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_q[3] && op == 3'd7 |=> t_q[0] && $stable(pc_q) && $stable(ac_q) && $stable(e_q));

  // R12
  write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (t_q[4] && (op == 3'd3 || op == 3'd5)) || (t_q[6] && op == 3'd6));
endmodule

bind acc_seq_core acc_seq_core_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_we(mem_we), .mem_rdata(mem_rdata), .pc_q(pc_q), .ar_q(ar_q),
  .ir_q(ir_q), .dr_q(dr_q), .ac_q(ac_q), .e_q(e_q), .i_q(i_q), .t_q(t_q)
);

// File: tb/acc_seq_core_test.sv
`timescale 1ns/1ps
module acc_seq_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [6:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata, ir_q, dr_q, ac_q;
  logic        mem_we, e_q, i_q;
  logic [11:0] pc_q, ar_q;
  logic [6:0]  t_q;

  acc_seq_core #(.ADDR_W(7)) uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .pc_q(pc_q), .ar_q(ar_q),
    .ir_q(ir_q), .dr_q(dr_q), .ac_q(ac_q), .e_q(e_q), .i_q(i_q), .t_q(t_q)
  );

  logic        ld_en = 1'b0;
  logic [6:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] mem [128];

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  logic [15:0] rm [128];
  logic [11:0] r_pc;
  logic [15:0] r_ac;
  logic        r_e;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd2: return "R5";
      3'd1:       return "R6";
      3'd3:       return "R7";
      3'd4:       return "R8";
      3'd5:       return "R9";
      3'd6:       return "R10";
      default:    return "R11";
    endcase
  endfunction

  function automatic logic [15:0] enc(input bit ind, input int k,
                                      input logic [2:0] op, input logic [6:0] a);
    if (ind) begin
      rm[7'h60 + k[6:0]] = 16'h0F80 | {9'd0, a};
      return {1'b1, op, 5'd0, 7'h60 + k[6:0]};
    end
    return {1'b0, op, 5'd0, a};
  endfunction

  task automatic build(input logic [15:0] a, input logic [15:0] b, input bit ind);
    for (int i = 0; i < 128; i++) rm[i] = 16'h0000;
    rm[0]  = enc(ind, 0,  3'd2, 7'h40);
    rm[1]  = enc(ind, 1,  3'd0, 7'h41);
    rm[2]  = enc(ind, 2,  3'd3, 7'h42);
    rm[3]  = enc(ind, 3,  3'd2, 7'h40);
    rm[4]  = enc(ind, 4,  3'd1, 7'h41);
    rm[5]  = enc(ind, 5,  3'd1, 7'h41);
    rm[6]  = enc(ind, 6,  3'd3, 7'h43);
    rm[7]  = enc(ind, 7,  3'd6, 7'h40);
    rm[8]  = ind ? 16'hF0A5 : 16'h7A5A;
    rm[9]  = enc(ind, 9,  3'd5, 7'h30);
    rm[10] = enc(ind, 10, 3'd6, 7'h44);
    rm[11] = enc(ind, 11, 3'd2, 7'h41);
    rm[12] = enc(ind, 12, 3'd4, 7'h0E);
    rm[13] = enc(ind, 13, 3'd2, 7'h41);
    rm[14] = 16'h7001;
    rm[7'h31] = 16'hC030;
    rm[7'h40] = a;
    rm[7'h41] = b;
    rm[7'h44] = 16'hFFFF;
  endtask

  task automatic load_and_reset();
    rst_n = 1'b0;
    ld_en = 1'b1;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      ld_addr = i[6:0];
      ld_data = rm[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    // R1: state while held in reset
    chk(t_q == 7'b0000001 && pc_q == 12'd0 && ar_q == 12'd0 && ac_q == 16'd0,
        "R1", "reset state {t,pc,ar,ac==0}", {t_q, pc_q, ar_q, 1'b0}, {7'b0000001, 25'd0});
    rst_n = 1'b1;
    r_pc = 12'd0;
    r_ac = 16'd0;
    r_e  = 1'b0;
  endtask

  task automatic step();
    logic [15:0] ir, opnd, v;
    logic [11:0] ea, old_pc;
    logic [2:0]  op;
    int n, exp_cyc, writes, exp_writes, mism;
    string tg;
    old_pc = r_pc;
    ir = rm[r_pc[6:0]];
    op = ir[14:12];
    tg = tag_of(op);
    ea = ir[11:0];
    if (op != 3'd7 && ir[15]) ea = rm[ea[6:0]][11:0];
    n = 0;
    writes = 0;
    do begin
      if (mem_we) writes++;
      @(negedge clk);
      n++;
      if (n == 1) chk(ar_q == old_pc, "R2", "address register after state 0", {20'd0, ar_q}, {20'd0, old_pc});
      if (n == 2) begin
        chk(ir_q == ir, "R2", "instruction register", {16'd0, ir_q}, {16'd0, ir});
        chk(pc_q == old_pc + 12'd1, "R2", "pc after fetch", {20'd0, pc_q}, {20'd0, old_pc + 12'd1});
      end
      if (n == 3) chk(ar_q == ir[11:0] && i_q == ir[15], "R3", "decode {i,ar}",
                      {19'd0, i_q, ar_q}, {19'd0, ir[15], ir[11:0]});
      if (n == 4 && op != 3'd7) chk(ar_q == ea, "R4", "effective address",
                                    {20'd0, ar_q}, {20'd0, ea});
    end while (!t_q[0] && n < 20);

    r_pc = r_pc + 12'd1;
    opnd = rm[ea[6:0]];
    exp_writes = 0;
    case (op)
      3'd0: begin r_ac = r_ac & opnd; exp_cyc = 6; end
      3'd1: begin {r_e, r_ac} = {1'b0, r_ac} + {1'b0, opnd}; exp_cyc = 6; end
      3'd2: begin r_ac = opnd; exp_cyc = 6; end
      3'd3: begin rm[ea[6:0]] = r_ac; exp_cyc = 5; exp_writes = 1; end
      3'd4: begin r_pc = ea; exp_cyc = 5; end
      3'd5: begin rm[ea[6:0]] = {4'd0, r_pc}; r_pc = ea + 12'd1; exp_cyc = 6; exp_writes = 1; end
      3'd6: begin
        v = opnd + 16'd1;
        rm[ea[6:0]] = v;
        if (v == 16'd0) r_pc = r_pc + 12'd1;
        exp_cyc = 7;
        exp_writes = 1;
      end
      default: exp_cyc = 4;
    endcase

    chk(n == exp_cyc, tg, "cycle count", n, exp_cyc);
    chk(pc_q == r_pc, tg, "pc", {20'd0, pc_q}, {20'd0, r_pc});
    chk(ac_q == r_ac, tg, "accumulator", {16'd0, ac_q}, {16'd0, r_ac});
    chk(e_q == r_e, tg, "carry flag", {31'd0, e_q}, {31'd0, r_e});
    mism = 0;
    for (int i = 0; i < 128; i++) if (mem[i] !== rm[i]) mism++;
    chk(mism == 0, tg, "memory words differing", mism, 0);
    // R12: one write strobe cycle only for store, call, increment
    chk(writes == exp_writes, "R12", "write strobe cycles", writes, exp_writes);
  endtask

  localparam logic [15:0] VALS [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                       16'hFFFF, 16'h1234, 16'h00FF, 16'hF0F0};

  initial begin
    for (int m = 0; m < 2; m++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++) begin
          int steps;
          build(VALS[ia], VALS[ib], m[0]);
          load_and_reset();
          steps = 0;
          while (r_pc[6:0] != 7'd15 && steps < 40) begin
            step();
            steps++;
          end
          chk(steps < 40, "R8", "program reached its end", steps, 40);
        end
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule